// File: doc/BRIEF.md
# Thresholded Weight Update Write Filter

This block sits between a gradient engine and the write port of a resistive weight array. Each training iteration is delivered as two passes over the same set of update deltas. During the scan pass the block only records the largest delta magnitude. During the apply pass it compares each delta against a threshold. The threshold is a small fixed fraction of that maximum, raised further for cells that have already taken many writes. Deltas that fall short are dropped with no array write. Deltas that clear the threshold produce a write request that carries the learning-rate-scaled new weight.

For every cell the block keeps a saturating wear counter that rises by one on each issued write. The counter feeds back into that cell's threshold, so heavily used cells are written less often. Per-iteration tallies of issued and suppressed writes are exposed for the training controller. A pulse on `iter_start` opens a new iteration.

Top module: `wupd_filter`

## Requirements
- R1: After reset, `wr_valid` is 0, both tallies are 0 and every wear counter is 0, so the first write to any cell reports `wr_count` = 1.
- R2: A beat with `in_pass` = 0 (scan) never produces a write and changes neither tally. It raises the stored maximum to |`in_delta`| when that magnitude is larger than the stored maximum.
- R3: The threshold for a cell is ((max × 41) >> 12) << (wear >> 2), where max is the stored maximum and wear is that cell's counter before the beat. An apply beat (`in_pass` = 1) passes when |`in_delta`| is greater than or equal to this threshold.
- R4: An apply beat below the threshold issues no write, increments `skipped_cnt`, and leaves the cell's wear counter unchanged.
- R5: An apply beat at or above the threshold asserts `wr_valid` for one cycle, on the cycle after the beat. The write carries `wr_addr` = `in_addr` and `wr_weight` = `in_weight` + floor(`lr` × `in_delta` / 16), where `lr` is unsigned with 4 fraction bits. The beat also increments `issued_cnt`.
- R6: Each issued write increments the cell's 4-bit wear counter and reports the new value on `wr_count`. At 15 the counter holds instead of wrapping.
- R7: `iter_start` clears the stored maximum and both tallies but keeps all wear counters. A beat presented in the same cycle is dropped.
- R8: The new weight saturates to the signed 16-bit range [-32768, 32767].
- R9: Magnitudes are absolute values of the two's-complement delta, and -32768 counts as 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iter_start | input | 1 | Opens a new iteration |
| in_valid | input | 1 | Delta beat valid |
| in_pass | input | 1 | 0 = scan pass, 1 = apply pass |
| in_addr | input | 4 | Cell address |
| in_delta | input | 16 | Signed update delta |
| in_weight | input | 16 | Signed current weight of the cell |
| lr | input | 8 | Learning rate, unsigned, 4 fraction bits |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 4 | Address to write |
| wr_weight | output | 16 | New signed weight |
| wr_count | output | 4 | Wear count of the cell after this write |
| issued_cnt | output | 16 | Writes issued this iteration |
| skipped_cnt | output | 16 | Writes suppressed this iteration |

## Verification
The properties assume an iteration never mixes the two passes: every scan beat comes before the first apply beat. They also assume `iter_start` is not raised together with a beat the stimulus depends on, and that the tallies do not wrap within an iteration. The stimulus opens each iteration with a lone `iter_start` pulse and sends all scan beats before any apply beat. It keeps every iteration far below 65536 beats. One cell is driven repeatedly so that its rising wear steps the threshold up and the counter reaches saturation.

// File: rtl/wupd_filter.sv
module wupd_filter #(
  parameter int ADDR_W     = 4,
  parameter int DELTA_W    = 16,
  parameter int WEIGHT_W   = 16,
  parameter int LR_W       = 8,
  parameter int LR_FRAC    = 4,
  parameter int CNT_W      = 4,
  parameter int WEAR_SHIFT = 2,
  parameter int FRAC_MUL   = 41,
  parameter int FRAC_SHIFT = 12,
  parameter int TALLY_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       iter_start,
  input  logic                       in_valid,
  input  logic                       in_pass,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic signed [DELTA_W-1:0]  in_delta,
  input  logic signed [WEIGHT_W-1:0] in_weight,
  input  logic [LR_W-1:0]            lr,
  output logic                       wr_valid,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic signed [WEIGHT_W-1:0] wr_weight,
  output logic [CNT_W-1:0]           wr_count,
  output logic [TALLY_W-1:0]         issued_cnt,
  output logic [TALLY_W-1:0]         skipped_cnt
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LVL_W  = CNT_W - WEAR_SHIFT;
  localparam int BASE_W = DELTA_W + $clog2(FRAC_MUL + 1);
  localparam int THR_W  = BASE_W + (1 << LVL_W) - 1;
  localparam int PW     = DELTA_W + LR_W + 1;
  localparam logic signed [PW:0] WMAX_X = (PW+1)'(2**(WEIGHT_W-1) - 1);
  localparam logic signed [PW:0] WMIN_X = -WMAX_X - 1;

  logic [CNT_W-1:0]   wear [DEPTH];
  logic [DELTA_W-1:0] max_abs;

  logic [DELTA_W-1:0] abs_d;
  logic [CNT_W-1:0]   cur_cnt, cnt_next;
  logic [LVL_W-1:0]   level;
  logic [BASE_W-1:0]  base;
  logic [THR_W-1:0]   thr;
  logic               pass_ok;
  logic signed [PW-1:0] prod, scaled;
  logic signed [PW:0]   sum;
  logic signed [WEIGHT_W-1:0] new_w;

  assign abs_d    = in_delta[DELTA_W-1] ? DELTA_W'(-in_delta) : DELTA_W'(in_delta);
  assign cur_cnt  = wear[in_addr];
  assign cnt_next = (&cur_cnt) ? cur_cnt : cur_cnt + 1'b1;
  assign level    = cur_cnt[CNT_W-1:WEAR_SHIFT];
  assign base     = (BASE_W'(max_abs) * BASE_W'(FRAC_MUL)) >> FRAC_SHIFT;
  assign thr      = THR_W'(base) << level;
  assign pass_ok  = THR_W'(abs_d) >= thr;

  assign prod   = $signed({1'b0, lr}) * in_delta;
  assign scaled = prod >>> LR_FRAC;
  assign sum    = (PW+1)'(in_weight) + (PW+1)'(scaled);
  assign new_w  = (sum > WMAX_X) ? WEIGHT_W'(WMAX_X) :
                  (sum < WMIN_X) ? WEIGHT_W'(WMIN_X) : sum[WEIGHT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_weight   <= '0;
      wr_count    <= '0;
      max_abs     <= '0;
      issued_cnt  <= '0;
      skipped_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) wear[i] <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (iter_start) begin
        max_abs     <= '0;
        issued_cnt  <= '0;
        skipped_cnt <= '0;
      end else if (in_valid) begin
        if (!in_pass) begin
          if (abs_d > max_abs) max_abs <= abs_d;
        end else if (pass_ok) begin
          wr_valid      <= 1'b1;
          wr_addr       <= in_addr;
          wr_weight     <= new_w;
          wr_count      <= cnt_next;
          wear[in_addr] <= cnt_next;
          issued_cnt    <= issued_cnt + 1'b1;
        end else begin
          skipped_cnt <= skipped_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wupd_filter_chk.sv
module wupd_filter_chk #(
  parameter int DELTA_W = 16,
  parameter int CNT_W   = 4,
  parameter int TALLY_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               iter_start,
  input logic               in_valid,
  input logic               in_pass,
  input logic               wr_valid,
  input logic [CNT_W-1:0]   wr_count,
  input logic [DELTA_W-1:0] max_abs,
  input logic [TALLY_W-1:0] issued_cnt,
  input logic [TALLY_W-1:0] skipped_cnt
);
  AST_SCAN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_pass |=> !wr_valid); // R2

  AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    !iter_start |=> max_abs >= $past(max_abs)); // R2

  AST_ONE_TALLY_STEP: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_pass && !iter_start |=>
      (issued_cnt + skipped_cnt) == ($past(issued_cnt) + $past(skipped_cnt) + 1'b1)); // R4

  AST_WRITE_MATCHES_ISSUE: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_pass && !iter_start |=> wr_valid == (issued_cnt != $past(issued_cnt))); // R5

  AST_WRITE_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_count != '0); // R6

  AST_ITER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    iter_start |=> issued_cnt == '0 && skipped_cnt == '0 && max_abs == '0); // R7
endmodule

bind wupd_filter wupd_filter_chk #(.DELTA_W(DELTA_W), .CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_chk (
  .clk(clk), .rst(rst), .iter_start(iter_start), .in_valid(in_valid), .in_pass(in_pass),
  .wr_valid(wr_valid), .wr_count(wr_count), .max_abs(max_abs),
  .issued_cnt(issued_cnt), .skipped_cnt(skipped_cnt)
);

// File: tb/sim_wupd_filter.sv
module sim_wupd_filter;
  logic clk = 0, rst = 1, iter_start = 0, in_valid = 0, in_pass = 0;
  logic [3:0] in_addr = 0;
  logic signed [15:0] in_delta = 0, in_weight = 0;
  logic [7:0] lr = 16;
  logic wr_valid;
  logic [3:0] wr_addr, wr_count;
  logic signed [15:0] wr_weight;
  logic [15:0] issued_cnt, skipped_cnt;

  typedef struct packed { logic [3:0] a; logic [15:0] w; logic [3:0] c; } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  longint mx = 0;
  int wear_m [16];
  int exp_iss = 0, exp_skp = 0;

  always #4 clk = ~clk;

  wupd_filter u0 (.clk, .rst, .iter_start, .in_valid, .in_pass, .in_addr, .in_delta,
    .in_weight, .lr, .wr_valid, .wr_addr, .wr_weight, .wr_count, .issued_cnt, .skipped_cnt);

  function automatic longint new_weight(longint w, longint d, longint l);
    longint r = w + ((l * d) >>> 4);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0; iter_start = 0;
  endtask

  task automatic new_iter();
    @(posedge clk); #1;
    in_valid = 0; iter_start = 1;
    mx = 0; exp_iss = 0; exp_skp = 0;
    idle();
  endtask

  task automatic beat(bit pass, int addr, longint d, longint w);
    longint a = (d < 0) ? -d : d;
    longint thr;
    item_t it;
    @(posedge clk); #1;
    iter_start = 0; in_valid = 1; in_pass = pass;
    in_addr = addr[3:0]; in_delta = 16'(d); in_weight = 16'(w);
    if (!pass) begin
      if (a > mx) mx = a;
    end else begin
      thr = ((mx * 41) >> 12) << (wear_m[addr] >> 2);
      if (a >= thr) begin
        if (wear_m[addr] < 15) wear_m[addr]++;
        it.a = addr[3:0];
        it.w = 16'(new_weight(w, d, longint'(lr)));
        it.c = 4'(wear_m[addr]);
        q.push_back(it);
        exp_iss++;
      end else exp_skp++;
    end
  endtask

  task automatic check_tallies(string req);
    idle();
    check({req, " issued"}, issued_cnt, exp_iss);
    check({req, " skipped"}, skipped_cnt, exp_skp);
  endtask

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      item_t e;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected write actual addr=%0d expected none", wr_addr);
      end else begin
        e = q.pop_front();
        if (wr_addr != e.a || wr_weight != $signed(e.w) || wr_count != e.c) begin
          fails++;
          $display("FAIL R5/R6 actual a=%0d w=%0d c=%0d expected a=%0d w=%0d c=%0d",
                   wr_addr, wr_weight, wr_count, e.a, $signed(e.w), e.c);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) wear_m[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    check("R1 wr_valid", wr_valid, 0);
    check("R1 issued", issued_cnt, 0);
    check("R1 skipped", skipped_cnt, 0);

    // R2 scan pass, R9 magnitudes of negative deltas
    new_iter();
    lr = 16;
    beat(0, 0, 100, 0);
    beat(0, 0, -5000, 0);
    beat(0, 0, 30, 0);
    check_tallies("R2");
    // R3/R4/R5 thresholds at base 50, R8 saturation, R9 most negative delta
    beat(1, 1, 100, 0);
    beat(1, 2, 49, 7);
    beat(1, 3, -50, 10);
    beat(1, 4, 5000, 30000);
    beat(1, 5, -32768, -1000);
    beat(1, 6, 50, -20);
    beat(1, 2, -49, 7);
    check_tallies("R4");

    // R5 fractional learning rate with floor rounding
    new_iter();
    check("R7 issued cleared", issued_cnt, 0);
    check("R7 skipped cleared", skipped_cnt, 0);
    lr = 3;
    beat(0, 0, -800, 0);
    beat(1, 8, 100, 0);
    beat(1, 8, -100, 50);
    beat(1, 9, 7, 0);
    check_tallies("R5");

    // R3 wear-raised threshold, R6 saturation of wear counter
    new_iter();
    lr = 16;
    beat(0, 0, 4096, 0);
    for (int k = 0; k < 14; k++) beat(1, 7, 300, k);
    for (int k = 0; k < 6; k++) beat(1, 7, 1000, 0);
    check_tallies("R3");

    // R7 wear kept across iterations; zero-max iteration passes everything
    new_iter();
    beat(1, 1, 0, 5);
    beat(1, 7, 1, 5);
    check_tallies("R7");

    repeat (3) idle();
    check("R5 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule